// File: doc/BRIEF.md
# Execute-Stage Arithmetic Unit with Built-In Instruction Decode

This block is the arithmetic unit of the execute stage in a small five-stage pipeline. Each cycle it receives two data operands and the whole instruction word held in that stage. It works out the operation from the instruction word itself, so no separate operation-select input exists. The result is captured in an output register and appears one clock later.

Register-type instructions use an all-zero primary opcode. For these the low six bits select the operation: add, subtract, logical shift left, logical shift right, or bitwise inversion of the second operand. The two shifts take their distance from a five-bit field. Memory instructions use the same adder to form a byte address from the first operand and a sign-extended 16-bit displacement. An all-zero instruction word is a legal idle slot. Any code the block does not recognise gives a zero result.

Top module: `exu_alu`

## Requirements
- R1: While `rst` is high at a rising edge, `result` is 0 after that edge.
- R2: Every result is registered. `result` after edge n is computed from `op_a`, `op_b` and `instr` as sampled at edge n.
- R3: With primary opcode `instr[31:26]`=000000 and function `instr[5:0]`=100000, the result is `op_a + op_b` modulo 2^32.
- R4: With opcode 000000 and function 100010, the result is `op_a - op_b` modulo 2^32. It is computed as `op_a + ~op_b + 1` on the adder that also serves addition.
- R5: With opcode 000000 and function 000001, the result is `op_b` shifted left by `instr[10:6]` places, with zeros filled in.
- R6: With opcode 000000 and function 000010, the result is `op_b` shifted right logically by `instr[10:6]` places, with zeros filled in.
- R7: With opcode 000000 and function 000100, the result is `~op_b`.
- R8: With opcode 100011 (load) or 101011 (store), the result is `op_a` plus `instr[15:0]` sign-extended to 32 bits, modulo 2^32.
- R9: An all-zero instruction word is a legal no-operation and gives a result of 0.
- R10: Any other opcode, or any other function code under opcode 000000, gives a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | 32 | First operand (base register value) |
| op_b | input | 32 | Second operand (shifted and inverted operand) |
| instr | input | 32 | Instruction word held in the execute stage |
| result | output | 32 | Registered result |

## Verification
The assertions assume nothing about the operands. Any 32-bit value is legal, and the add and subtract paths may wrap freely. They do assume that every input is a defined 0/1 value at each clock edge, and that decode is judged only on the opcode, function and shift fields. The stimulus never leaves that space: random operands and random instruction words come from a seeded generator, and some random words are deliberately illegal. These are mixed with directed cases: shift distances 0 and 31, additions and subtractions that wrap, negative displacements, and the all-zero word.

// File: rtl/exu_alu_pkg.sv
package exu_alu_pkg;
  localparam int INSTR_W = 32;
  localparam int OPC_HI  = 31;
  localparam int OPC_LO  = 26;
  localparam int FN_HI   = 5;
  localparam int FN_LO   = 0;
  localparam int SH_HI   = 10;
  localparam int SH_LO   = 6;
  localparam int IMM_W   = 16;

  localparam logic [5:0] OPC_REG   = 6'b000000;
  localparam logic [5:0] OPC_LOAD  = 6'b100011;
  localparam logic [5:0] OPC_STORE = 6'b101011;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_SHL = 6'b000001;
  localparam logic [5:0] FN_SHR = 6'b000010;
  localparam logic [5:0] FN_INV = 6'b000100;

  typedef enum int {
    U_ADD = 0,
    U_SUB = 1,
    U_SHL = 2,
    U_SHR = 3,
    U_INV = 4
  } unit_e;

  localparam int NUM_UNITS = 5;
endpackage

// File: rtl/exu_alu_decode.sv
module exu_alu_decode
  import exu_alu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [INSTR_W-1:0]   instr,
  output logic [NUM_UNITS-1:0] sel,
  output logic                 use_imm,
  output logic                 bad_code
);
  logic [5:0] opc;
  logic [5:0] fn;

  assign opc = instr[OPC_HI:OPC_LO];
  assign fn  = instr[FN_HI:FN_LO];

  always_comb begin
    sel     = '0;
    use_imm = 1'b0;
    if (opc == OPC_REG) begin
      case (fn)
        FN_ADD:  sel[U_ADD] = 1'b1;
        FN_SUB:  sel[U_SUB] = 1'b1;
        FN_SHL:  sel[U_SHL] = 1'b1;
        FN_SHR:  sel[U_SHR] = 1'b1;
        FN_INV:  sel[U_INV] = 1'b1;
        default: sel = '0;
      endcase
    end else if (opc == OPC_LOAD || opc == OPC_STORE) begin
      sel[U_ADD] = 1'b1;
      use_imm    = 1'b1;
    end
  end

  assign bad_code = (sel == '0);

  // R10: at most one unit is ever picked
  assert_one_unit_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));

  // R8: displacement is used only when the adder is the chosen unit
  assert_imm_only_on_add_R8: assert property (@(posedge clk) disable iff (rst)
    use_imm |-> (sel[U_ADD] && opc != OPC_REG));

  // R9: the all-zero word selects no unit
  assert_zero_word_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (instr == '0) |-> bad_code);
endmodule

// File: rtl/exu_alu_adder.sv
module exu_alu_adder #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] sum
);
  logic [DATA_W-1:0] b_eff;

  assign b_eff = b ^ {DATA_W{sub}};
  assign sum   = a + b_eff + {{(DATA_W-1){1'b0}}, sub};

  // R4: a difference plus the subtrahend gives back the minuend
  assert_sub_undo_R4: assert property (@(posedge clk) disable iff (rst)
    sub |-> ((sum + b) == a));

  // R3: a sum minus one addend gives back the other
  assert_add_undo_R3: assert property (@(posedge clk) disable iff (rst)
    !sub |-> ((sum - b) == a));
endmodule

// File: rtl/exu_alu_shift.sv
module exu_alu_shift #(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  input  logic [AMT_W-1:0]  amt,
  input  logic              left,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] stage [0:AMT_W];

  assign stage[0] = din;

  generate
    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
      localparam int DIST = 1 << s;
      always_comb begin
        if (!amt[s])
          stage[s+1] = stage[s];
        else if (left)
          stage[s+1] = stage[s] << DIST;
        else
          stage[s+1] = stage[s] >> DIST;
      end
    end
  endgenerate

  assign dout = stage[AMT_W];

  // R5: vacated low bits are zero after a left shift
  assert_left_fill_R5: assert property (@(posedge clk) disable iff (rst)
    left |-> ((dout & ((DATA_W'(1) << amt) - DATA_W'(1))) == '0));

  // R6: vacated high bits are zero after a right shift
  assert_right_fill_R6: assert property (@(posedge clk) disable iff (rst)
    !left |-> ((dout & ~({DATA_W{1'b1}} >> amt)) == '0));

  // R5: a zero distance passes the operand through
  assert_zero_dist_R5: assert property (@(posedge clk) disable iff (rst)
    (amt == '0) |-> (dout == din));
endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [INSTR_W-1:0] instr,
  output logic [DATA_W-1:0] result
);
  logic [NUM_UNITS-1:0] sel;
  logic                 use_imm;
  logic                 bad_code;
  logic [DATA_W-1:0]    imm_ext;
  logic [DATA_W-1:0]    add_b;
  logic [DATA_W-1:0]    add_out;
  logic [DATA_W-1:0]    sh_out;
  logic [DATA_W-1:0]    unit_out [NUM_UNITS];
  logic [DATA_W-1:0]    next_res;

  exu_alu_decode u_dec (
    .clk      (clk),
    .rst      (rst),
    .instr    (instr),
    .sel      (sel),
    .use_imm  (use_imm),
    .bad_code (bad_code)
  );

  assign imm_ext = {{(DATA_W-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};
  assign add_b   = use_imm ? imm_ext : op_b;

  exu_alu_adder #(.DATA_W(DATA_W)) u_add (
    .clk (clk),
    .rst (rst),
    .a   (op_a),
    .b   (add_b),
    .sub (sel[U_SUB]),
    .sum (add_out)
  );

  exu_alu_shift #(.DATA_W(DATA_W)) u_shf (
    .clk  (clk),
    .rst  (rst),
    .din  (op_b),
    .amt  (instr[SH_LO +: AMT_W]),
    .left (sel[U_SHL]),
    .dout (sh_out)
  );

  assign unit_out[U_ADD] = add_out;
  assign unit_out[U_SUB] = add_out;
  assign unit_out[U_SHL] = sh_out;
  assign unit_out[U_SHR] = sh_out;
  assign unit_out[U_INV] = ~op_b;

  always_comb begin
    next_res = '0;
    for (int u = 0; u < NUM_UNITS; u++)
      next_res = next_res | (unit_out[u] & {DATA_W{sel[u]}});
  end

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else     result <= next_res;
  end

  // R1: reset clears the output register
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (result == '0));

  // R10: an unrecognised code yields zero one cycle later
  assert_bad_code_zero_R10: assert property (@(posedge clk) disable iff (rst)
    bad_code |=> (result == '0));

  // R7: inversion result and operand share no set bit
  assert_inv_disjoint_R7: assert property (@(posedge clk) disable iff (rst)
    sel[U_INV] |=> ((result & $past(op_b)) == '0));

  // R2: output changes only through a registered update
  assert_hold_when_same_R2: assert property (@(posedge clk) disable iff (rst)
    ($stable(op_a) && $stable(op_b) && $stable(instr)) |=> $stable(result));
endmodule

// File: tb/exu_alu_tb.sv
module exu_alu_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] op_a, op_b, instr;
  logic [31:0] result;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done  = 1'b0;

  always #2 clk = ~clk;

  exu_alu u_dut (
    .clk    (clk),
    .rst    (rst),
    .op_a   (op_a),
    .op_b   (op_b),
    .instr  (instr),
    .result (result)
  );

  function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b, logic [31:0] w);
    logic [5:0]  opc = w[31:26];
    logic [5:0]  fn  = w[5:0];
    logic [4:0]  sh  = w[10:6];
    logic [31:0] ext = {{16{w[15]}}, w[15:0]};
    if (opc == 6'b000000) begin
      case (fn)
        6'b100000: return a + b;
        6'b100010: return a - b;
        6'b000001: return b << sh;
        6'b000010: return b >> sh;
        6'b000100: return ~b;
        default:   return 32'h0;
      endcase
    end
    if (opc == 6'b100011 || opc == 6'b101011) return a + ext;
    return 32'h0;
  endfunction

  function automatic string tag(logic [31:0] w);
    if (w == 32'h0) return "R9";
    if (w[31:26] == 6'b100011 || w[31:26] == 6'b101011) return "R8";
    if (w[31:26] != 6'b000000) return "R10";
    case (w[5:0])
      6'b100000: return "R3";
      6'b100010: return "R4";
      6'b000001: return "R5";
      6'b000010: return "R6";
      6'b000100: return "R7";
      default:   return "R10";
    endcase
  endfunction

  function automatic logic [31:0] rword(logic [5:0] fn, logic [4:0] sh);
    return {6'b000000, 5'($urandom), 5'($urandom), 5'($urandom), sh, fn};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: result=%h expected=%h", req, act, exp);
    end
  endtask

  // drive 1ns after a rising edge, check 1ns after the next one
  task automatic run(logic [31:0] a, logic [31:0] b, logic [31:0] w);
    op_a = a; op_b = b; instr = w;
    @(posedge clk); #1;
    check(tag(w), result, model(a, b, w));
    // R2: value was taken from inputs at the capturing edge
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; op_a = 32'hFFFF_FFFF; op_b = 32'h1234_5678; instr = rword(6'b100000, 5'd0);
    @(posedge clk); #1;
    check("R1", result, 32'h0);
    @(posedge clk); #1;
    check("R1", result, 32'h0);
    rst = 1'b0;

    // directed corners
    run(32'hFFFF_FFFF, 32'h0000_0001, rword(6'b100000, 5'd3));   // R3 wrap
    run(32'h8000_0000, 32'h8000_0000, rword(6'b100000, 5'd0));   // R3 wrap
    run(32'h0000_0000, 32'h0000_0001, rword(6'b100010, 5'd0));   // R4 borrow
    run(32'h7FFF_FFFF, 32'hFFFF_FFFF, rword(6'b100010, 5'd9));   // R4
    run(32'hDEAD_BEEF, 32'h8000_0001, rword(6'b000001, 5'd0));   // R5 zero shift
    run(32'h0, 32'hFFFF_FFFF, rword(6'b000001, 5'd31));          // R5 max shift
    run(32'h0, 32'h8000_0001, rword(6'b000010, 5'd0));           // R6 zero shift
    run(32'h0, 32'hFFFF_FFFF, rword(6'b000010, 5'd31));          // R6 max shift
    run(32'h1, 32'h0F0F_00FF, rword(6'b000100, 5'd7));           // R7
    run(32'h0000_1000, 32'h5, {6'b100011, 10'h3FF, 16'hFFFC});   // R8 load, negative
    run(32'hFFFF_FFF0, 32'h5, {6'b101011, 10'h155, 16'h0020});   // R8 store, wrap
    run(32'h1234_5678, 32'h9ABC_DEF0, 32'h0000_0000);            // R9 nop
    run(32'h1234_5678, 32'h9ABC_DEF0, rword(6'b000000, 5'd4));   // R10 bad fn
    run(32'h1234_5678, 32'h9ABC_DEF0, rword(6'b100001, 5'd4));   // R10 bad fn
    run(32'h1234_5678, 32'h9ABC_DEF0, {6'b001000, 26'h3FF_FFFF}); // R10 bad opcode

    // R1: reset mid-stream clears the output
    op_a = 32'h5; op_b = 32'h6; instr = rword(6'b100000, 5'd0); rst = 1'b1;
    @(posedge clk); #1;
    check("R1", result, 32'h0);
    rst = 1'b0;

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w;
      int pick = $urandom_range(0, 9);
      case (pick)
        0: w = rword(6'b100000, 5'($urandom));
        1: w = rword(6'b100010, 5'($urandom));
        2: w = rword(6'b000001, 5'($urandom));
        3: w = rword(6'b000010, 5'($urandom));
        4: w = rword(6'b000100, 5'($urandom));
        5: w = {6'b100011, 26'($urandom)};
        6: w = {6'b101011, 26'($urandom)};
        7: w = 32'h0;
        8: w = rword(6'($urandom), 5'($urandom));
        default: w = $urandom;
      endcase
      run($urandom, $urandom, w);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end
endmodule